// File: doc/BRIEF.md
# Vector Load/Store Element Sequencer

This block turns one vector memory operation into a series of single-element memory requests. When `start` is pulsed it captures a configuration: operation mode, addressing kind, vector/scalar flags for the base, offset and destination operands, an element width, a sign-extend option, a cache-inhibit flag, a vector length and three starting register numbers. It then issues one request per element. Each request carries an effective address and the base, offset and destination register numbers for that element. The block reads the base and offset register contents through two combinational read ports keyed by the register numbers it emits.

Only one request is outstanding at a time. Each request is closed by a response that says whether the element faulted. At the end the block pulses `done` and presents the final vector length and whether an exception must be raised.

In fail-first mode the block behaves differently on faults. A fault on element 0 is raised as an ordinary exception. A fault on any later element is absorbed: the vector length shrinks to the count of elements that completed, and no exception is reported.

Top module: `vls_elem_seq`

## Requirements
- R1: A start with a vector length of 0 issues no request and asserts `done` in the next cycle with `done_vl` = 0 and `done_exc` = 0; at most `vl_in` requests are issued for any operation.
- R2: `mode` 00 is normal, 01 is fail-first, 10 is saturate and 11 is predicate-result. Modes 00, 10 and 11 sequence identically.
- R3: When `dst_vec` is 0, exactly one request is issued, and `done_vl` equals `vl_in`.
- R4: With `amode` 00 (indexed) and both `base_vec` and `off_vec` at 0, one request is issued. If `cinh` is 1, `vl_in` requests are issued instead, all to the same address, with successive destination numbers.
- R5: The destination number is `rt_idx` + i for element i. With `amode` 00, the base number advances by one per element only when `base_vec` is 1, and the offset number only when `off_vec` is 1. With other `amode` values both stay fixed.
- R6: With `amode` 10 or 11 (strided), the address of element i is base + i × stride modulo 2^ADDR_W. With `amode` 01 (unit), the stride is the element size in bytes: `ew` 0, 1, 2, 3 give 1, 2, 4, 8.
- R7: The offset register value is cut to the element width, which is 8 << `ew` bits. In strided mode with `sext` = 1 the cut value is sign-extended; in every other case it is zero-extended. In indexed mode the address is base + extended offset.
- R8: In fail-first mode a fault on element 0 ends the operation with `done_exc` = 1 and `done_vl` = `vl_in`.
- R9: In fail-first mode a fault on element i ≥ 1 ends the operation after that element with `done_vl` = i and `done_exc` = 0.
- R10: In fail-first mode with `amode` 00 and `base_vec` = 1, addressing is strided, and the base and offset numbers stay fixed.
- R11: A fail-first operation with a nonzero `vl_in` never reports `done_vl` = 0.
- R12: After reset the block is idle with `req_valid` and `done` low. A new request is never issued while one is outstanding, and `done` is a single-cycle pulse.
- R13: In a non-fail-first mode, a fault on any element ends the operation after that element with `done_exc` = 1 and `done_vl` = `vl_in`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| mode | input | 2 | Operation mode (normal, fail-first, saturate, predicate-result) |
| amode | input | 2 | Addressing kind: indexed, unit, strided |
| base_vec | input | 1 | Base operand is a vector |
| off_vec | input | 1 | Offset operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| sext | input | 1 | Sign-extend the stride in strided addressing |
| cinh | input | 1 | Cache-inhibited access: repeat scalar-scalar accesses |
| ew | input | 2 | Element width code, 8 << ew bits |
| vl_in | input | VL_W | Vector length |
| ra_idx | input | RIDX_W | Starting base register number |
| rb_idx | input | RIDX_W | Starting offset register number |
| rt_idx | input | RIDX_W | Starting destination register number |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Element request present this cycle |
| req_addr | output | ADDR_W | Effective address of the element |
| req_dst_idx | output | RIDX_W | Destination register number of the element |
| req_ra_idx | output | RIDX_W | Base register number to read |
| req_rb_idx | output | RIDX_W | Offset register number to read |
| ra_val | input | ADDR_W | Contents of register `req_ra_idx` |
| rb_val | input | ADDR_W | Contents of register `req_rb_idx` |
| rsp_valid | input | 1 | Response for the outstanding element |
| rsp_fault | input | 1 | The element faulted |
| done | output | 1 | Operation complete, one cycle |
| done_vl | output | VL_W | Final vector length |
| done_exc | output | 1 | An exception must be raised |

## Verification
The bound checker watches, on every cycle, the protocol shape of the block. It checks that only one request is outstanding, that `done` lasts one cycle, that a zero length finishes at once, and that the destination number steps by one per element. It also checks that a scalar destination never gets a second request, and that fail-first results keep a nonzero length that never exceeds the starting one. The actual address values can only be shown by the bench's directed scenarios, because they depend on register contents: unit and strided steps, sign versus zero extension, modulo wrap, fail-first redirection of indexed addressing, and the cache-inhibited repeat. The same holds for which base and offset numbers advance and for the exact element count at which a fault stops the run.

// File: rtl/vls_pkg.sv
package vls_pkg;

   typedef enum logic [1:0] {
      MD_NORMAL = 2'b00,
      MD_FFIRST = 2'b01,
      MD_SAT    = 2'b10,
      MD_PRED   = 2'b11
   } vls_mode_e;

   typedef enum logic [1:0] {
      AM_INDEXED    = 2'b00,
      AM_UNIT       = 2'b01,
      AM_STRIDED    = 2'b10,
      AM_STRIDED_B  = 2'b11
   } vls_amode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_FIN
   } vls_state_e;

   // register-number lanes tracked per element
   localparam int NUM_IDX  = 3;
   localparam int LANE_RA  = 0;
   localparam int LANE_RB  = 1;
   localparam int LANE_RT  = 2;

   typedef struct packed {
      vls_mode_e  mode;
      vls_amode_e amode;
      logic       base_vec;
      logic       off_vec;
      logic       dst_vec;
      logic       sext;
      logic       cinh;
      logic [1:0] ew;
   } vls_cfg_t;

   function automatic int ew_bits(input logic [1:0] code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
   import vls_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int VL_W       = 8,
   parameter bit STRIDE_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic              use_stride,
   input  logic              use_unit,
   input  logic              sext,
   input  logic [1:0]        ew,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] off_val,
   output logic [ADDR_W-1:0] ea
);

   logic [ADDR_W-1:0]        off_zx;
   logic [ADDR_W-1:0]        off_sx;
   logic signed [ADDR_W-1:0] sx_tmp;
   logic [ADDR_W-1:0]        step_amt;
   logic [ADDR_W-1:0]        elem_off;
   int                       sh;

   // cut the offset register to the element width
   always_comb begin
      sh     = ADDR_W - ew_bits(ew);
      off_zx = (off_val << sh) >> sh;
      sx_tmp = off_val << sh;
      off_sx = sx_tmp >>> sh;
   end

   always_comb begin
      if (use_unit)
         step_amt = ADDR_W'(1) << ew;
      else if (sext)
         step_amt = off_sx;
      else
         step_amt = off_zx;
   end

   generate
      if (STRIDE_MUL) begin : g_mul
         logic [VL_W-1:0] elem_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               elem_q <= '0;
            else if (clear)
               elem_q <= '0;
            else if (step)
               elem_q <= elem_q + 1'b1;
         end
         assign elem_off = ADDR_W'(elem_q) * step_amt;
      end else begin : g_acc
         logic [ADDR_W-1:0] acc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               acc_q <= '0;
            else if (clear)
               acc_q <= '0;
            else if (step)
               acc_q <= acc_q + step_amt;
         end
         assign elem_off = acc_q;
      end
   endgenerate

   assign ea = (use_stride || use_unit) ? base_val + elem_off
                                        : base_val + off_zx;

endmodule

// File: rtl/vls_idx_track.sv
module vls_idx_track
   import vls_pkg::*;
#(
   parameter int RIDX_W = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic                            step,
   input  logic [NUM_IDX-1:0][RIDX_W-1:0]  init_idx,
   input  logic [NUM_IDX-1:0]              adv_en,
   output logic [NUM_IDX-1:0][RIDX_W-1:0]  cur_idx
);

   for (genvar g = 0; g < NUM_IDX; g++) begin : g_lane
      logic [RIDX_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (load)
            lane_q <= init_idx[g];
         else if (step && adv_en[g])
            lane_q <= lane_q + 1'b1;
      end
      assign cur_idx[g] = lane_q;
   end

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
   import vls_pkg::*;
#(
   parameter int VL_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VL_W-1:0] vl_in,
   input  logic            ffirst,
   input  logic            single_elem,
   input  logic            rsp_valid,
   input  logic            rsp_fault,
   output logic            busy,
   output logic            load,
   output logic            issue,
   output logic            step,
   output logic            done,
   output logic [VL_W-1:0] done_vl,
   output logic            done_exc
);

   vls_state_e      st_q;
   logic [VL_W-1:0] vl_q;
   logic [VL_W-1:0] cnt_q;
   logic            accept;
   logic            last_elem;
   logic            late_fault;

   assign load       = start && (st_q == ST_IDLE);
   assign accept     = (st_q == ST_WAIT) && rsp_valid;
   assign last_elem  = single_elem || (cnt_q == vl_q - 1'b1);
   assign late_fault = ffirst && (cnt_q != '0);
   assign step       = accept && !rsp_fault && !last_elem;
   assign busy       = (st_q != ST_IDLE);
   assign issue      = (st_q == ST_ISSUE);
   assign done       = (st_q == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         vl_q     <= '0;
         cnt_q    <= '0;
         done_vl  <= '0;
         done_exc <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  vl_q     <= vl_in;
                  cnt_q    <= '0;
                  done_vl  <= vl_in;
                  done_exc <= 1'b0;
                  st_q     <= (vl_in == '0) ? ST_FIN : ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_fault) begin
                     st_q <= ST_FIN;
                     if (late_fault)
                        done_vl <= cnt_q;
                     else
                        done_exc <= 1'b1;
                  end else if (last_elem) begin
                     st_q <= ST_FIN;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                     st_q  <= ST_ISSUE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vls_elem_seq.sv
module vls_elem_seq
   import vls_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int VL_W       = 8,
   parameter int RIDX_W     = 7,
   parameter bit STRIDE_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [1:0]        amode,
   input  logic              base_vec,
   input  logic              off_vec,
   input  logic              dst_vec,
   input  logic              sext,
   input  logic              cinh,
   input  logic [1:0]        ew,
   input  logic [VL_W-1:0]   vl_in,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [RIDX_W-1:0] rb_idx,
   input  logic [RIDX_W-1:0] rt_idx,
   output logic              busy,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [RIDX_W-1:0] req_dst_idx,
   output logic [RIDX_W-1:0] req_ra_idx,
   output logic [RIDX_W-1:0] req_rb_idx,
   input  logic [ADDR_W-1:0] ra_val,
   input  logic [ADDR_W-1:0] rb_val,
   input  logic              rsp_valid,
   input  logic              rsp_fault,
   output logic              done,
   output logic [VL_W-1:0]   done_vl,
   output logic              done_exc
);

   generate
      if (ADDR_W < 64) begin : g_bad_addr_w
         $error("vls_elem_seq: ADDR_W must hold a 64-bit element");
      end
      if (VL_W < 1) begin : g_bad_vl_w
         $error("vls_elem_seq: VL_W must be at least 1");
      end
      if (RIDX_W < 1) begin : g_bad_ridx_w
         $error("vls_elem_seq: RIDX_W must be at least 1");
      end
   endgenerate

   vls_cfg_t cfg_q;
   logic     load;
   logic     step;
   logic     issue;
   logic     is_ffirst;
   logic     redirect;
   logic     k_stride;
   logic     k_unit;
   logic     k_index;
   logic     single_elem;

   logic [NUM_IDX-1:0][RIDX_W-1:0] init_idx;
   logic [NUM_IDX-1:0][RIDX_W-1:0] cur_idx;
   logic [NUM_IDX-1:0]             adv_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (load) begin
         cfg_q.mode     <= vls_mode_e'(mode);
         cfg_q.amode    <= vls_amode_e'(amode);
         cfg_q.base_vec <= base_vec;
         cfg_q.off_vec  <= off_vec;
         cfg_q.dst_vec  <= dst_vec;
         cfg_q.sext     <= sext;
         cfg_q.cinh     <= cinh;
         cfg_q.ew       <= ew;
      end
   end

   // addressing kind after the fail-first redirection
   always_comb begin
      is_ffirst   = (cfg_q.mode == MD_FFIRST);
      redirect    = is_ffirst && (cfg_q.amode == AM_INDEXED) && cfg_q.base_vec;
      k_unit      = (cfg_q.amode == AM_UNIT);
      k_stride    = (cfg_q.amode == AM_STRIDED) || (cfg_q.amode == AM_STRIDED_B) || redirect;
      k_index     = !k_unit && !k_stride;
      single_elem = !cfg_q.dst_vec ||
                    (k_index && !cfg_q.base_vec && !cfg_q.off_vec && !cfg_q.cinh);
   end

   always_comb begin
      init_idx[LANE_RA] = ra_idx;
      init_idx[LANE_RB] = rb_idx;
      init_idx[LANE_RT] = rt_idx;
      adv_en[LANE_RA]   = k_index && cfg_q.base_vec;
      adv_en[LANE_RB]   = k_index && cfg_q.off_vec;
      adv_en[LANE_RT]   = 1'b1;
   end

   vls_ctrl #(
      .VL_W (VL_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .vl_in       (vl_in),
      .ffirst      (is_ffirst),
      .single_elem (single_elem),
      .rsp_valid   (rsp_valid),
      .rsp_fault   (rsp_fault),
      .busy        (busy),
      .load        (load),
      .issue       (issue),
      .step        (step),
      .done        (done),
      .done_vl     (done_vl),
      .done_exc    (done_exc)
   );

   vls_idx_track #(
      .RIDX_W (RIDX_W)
   ) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .init_idx (init_idx),
      .adv_en   (adv_en),
      .cur_idx  (cur_idx)
   );

   vls_addr_gen #(
      .ADDR_W     (ADDR_W),
      .VL_W       (VL_W),
      .STRIDE_MUL (STRIDE_MUL)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (load),
      .step       (step),
      .use_stride (k_stride),
      .use_unit   (k_unit),
      .sext       (cfg_q.sext),
      .ew         (cfg_q.ew),
      .base_val   (ra_val),
      .off_val    (rb_val),
      .ea         (req_addr)
   );

   assign req_valid   = issue;
   assign req_ra_idx  = cur_idx[LANE_RA];
   assign req_rb_idx  = cur_idx[LANE_RB];
   assign req_dst_idx = cur_idx[LANE_RT];

endmodule

// File: rtl/vls_elem_seq_chk.sv
module vls_elem_seq_chk #(
   parameter int VL_W   = 8,
   parameter int RIDX_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        mode,
   input logic              dst_vec,
   input logic [VL_W-1:0]   vl_in,
   input logic [RIDX_W-1:0] rt_idx,
   input logic              busy,
   input logic              req_valid,
   input logic [RIDX_W-1:0] req_dst_idx,
   input logic              rsp_valid,
   input logic              done,
   input logic [VL_W-1:0]   done_vl,
   input logic              done_exc
);

   logic              outst_q;
   logic [VL_W-1:0]   cnt_q;
   logic [VL_W-1:0]   vl_q;
   logic [1:0]        mode_q;
   logic              dvec_q;
   logic [RIDX_W-1:0] rt_q;
   logic [RIDX_W-1:0] dst_exp;
   logic              accepted;

   assign accepted = start && !busy;
   assign dst_exp  = rt_q + RIDX_W'(cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst_q <= 1'b0;
         cnt_q   <= '0;
         vl_q    <= '0;
         mode_q  <= '0;
         dvec_q  <= 1'b0;
         rt_q    <= '0;
      end else begin
         if (accepted) begin
            cnt_q  <= '0;
            vl_q   <= vl_in;
            mode_q <= mode;
            dvec_q <= dst_vec;
            rt_q   <= rt_idx;
         end else if (rsp_valid && outst_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (req_valid)
            outst_q <= 1'b1;
         else if (rsp_valid)
            outst_q <= 1'b0;
      end
   end

   AST_ZERO_VL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && (vl_in == '0) |=> done && (done_vl == '0)); // R1

   AST_REQ_WITHIN_VL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (cnt_q < vl_q)); // R1

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !outst_q); // R12

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_SCALAR_DST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !dvec_q |-> (cnt_q == '0)); // R3

   AST_DST_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_dst_idx == dst_exp)); // R5

   AST_FF_EARLY_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_exc && (mode_q == 2'b01) |-> (done_vl == vl_q)); // R8

   AST_VL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_vl <= vl_q)); // R9

   AST_FF_VL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done && (mode_q == 2'b01) && (vl_q != '0) |-> (done_vl != '0)); // R11

endmodule

bind vls_elem_seq vls_elem_seq_chk #(
   .VL_W   (VL_W),
   .RIDX_W (RIDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .mode        (mode),
   .dst_vec     (dst_vec),
   .vl_in       (vl_in),
   .rt_idx      (rt_idx),
   .busy        (busy),
   .req_valid   (req_valid),
   .req_dst_idx (req_dst_idx),
   .rsp_valid   (rsp_valid),
   .done        (done),
   .done_vl     (done_vl),
   .done_exc    (done_exc)
);

// File: tb/vls_elem_seq_tb_top.sv
module vls_elem_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = '0;
   logic [1:0]  amode = '0;
   logic        base_vec = 1'b0;
   logic        off_vec = 1'b0;
   logic        dst_vec = 1'b0;
   logic        sext = 1'b0;
   logic        cinh = 1'b0;
   logic [1:0]  ew = '0;
   logic [7:0]  vl_in = '0;
   logic [6:0]  ra_idx = '0;
   logic [6:0]  rb_idx = '0;
   logic [6:0]  rt_idx = '0;
   logic        busy;
   logic        req_valid;
   logic [63:0] req_addr;
   logic [6:0]  req_dst_idx;
   logic [6:0]  req_ra_idx;
   logic [6:0]  req_rb_idx;
   logic [63:0] ra_val;
   logic [63:0] rb_val;
   logic        rsp_valid = 1'b0;
   logic        rsp_fault = 1'b0;
   logic        done;
   logic [7:0]  done_vl;
   logic        done_exc;

   logic [63:0] rf [0:127];

   int n_chk = 0;
   int n_err = 0;

   int          n_req;
   logic [63:0] cap_addr [0:15];
   logic [6:0]  cap_dst  [0:15];
   logic [6:0]  cap_ra   [0:15];
   logic [6:0]  cap_rb   [0:15];
   logic [7:0]  got_vl;
   logic        got_exc;

   always #5 clk = ~clk;

   assign ra_val = rf[req_ra_idx];
   assign rb_val = rf[req_rb_idx];

   vls_elem_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .amode(amode),
      .base_vec(base_vec), .off_vec(off_vec), .dst_vec(dst_vec), .sext(sext),
      .cinh(cinh), .ew(ew), .vl_in(vl_in), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .rt_idx(rt_idx), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
      .req_dst_idx(req_dst_idx), .req_ra_idx(req_ra_idx), .req_rb_idx(req_rb_idx),
      .ra_val(ra_val), .rb_val(rb_val), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .done(done), .done_vl(done_vl), .done_exc(done_exc)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   task automatic run_op(input logic [1:0] md, input logic [1:0] am,
                         input logic bv, input logic ov, input logic dv,
                         input logic sx, input logic ci, input logic [1:0] w,
                         input logic [7:0] vl, input logic [6:0] ra,
                         input logic [6:0] rb, input logic [6:0] rt,
                         input int fault_at);
      int  guard;
      bit  fin;
      bit  handled;
      @(negedge clk);
      mode = md; amode = am; base_vec = bv; off_vec = ov; dst_vec = dv;
      sext = sx; cinh = ci; ew = w; vl_in = vl;
      ra_idx = ra; rb_idx = rb; rt_idx = rt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n_req = 0; fin = 0; guard = 0;
      got_vl = '0; got_exc = 1'b0;
      while (!fin && guard < 2000) begin
         guard++;
         handled = 0;
         if (done) begin
            got_vl  = done_vl;
            got_exc = done_exc;
            fin     = 1;
         end else if (req_valid) begin
            if (n_req < 16) begin
               cap_addr[n_req] = req_addr;
               cap_dst[n_req]  = req_dst_idx;
               cap_ra[n_req]   = req_ra_idx;
               cap_rb[n_req]   = req_rb_idx;
            end
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_fault = (n_req == fault_at);
            n_req++;
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_fault = 1'b0;
            handled = 1;
         end
         if (!fin && !handled) @(negedge clk);
      end
      chk("R12 operation completes", 64'(fin), 64'd1);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R12 reset busy", 64'(busy), 64'd0);
      chk("R12 reset req_valid", 64'(req_valid), 64'd0);
      chk("R12 reset done", 64'(done), 64'd0);
   endtask

   task automatic t_zero_vl();
      run_op(2'b00, 2'b01, 0, 0, 1, 0, 0, 2'd2, 8'd0, 7'd5, 7'd6, 7'd10, -1);
      chk("R1 zero vl requests", 64'(n_req), 64'd0);
      chk("R1 zero vl done_vl", 64'(got_vl), 64'd0);
      chk("R1 zero vl exc", 64'(got_exc), 64'd0);
   endtask

   task automatic t_unit();
      run_op(2'b00, 2'b01, 0, 0, 1, 0, 0, 2'd2, 8'd4, 7'd5, 7'd6, 7'd10, -1);
      chk("R6 unit count", 64'(n_req), 64'd4);
      for (int i = 0; i < 4; i++) begin
         chk("R6 unit addr", cap_addr[i], rf[5] + 64'(4 * i));
         chk("R5 unit dst", 64'(cap_dst[i]), 64'(10 + i));
         chk("R5 unit ra fixed", 64'(cap_ra[i]), 64'd5);
         chk("R5 unit rb fixed", 64'(cap_rb[i]), 64'd6);
      end
      chk("R6 unit done_vl", 64'(got_vl), 64'd4);
   endtask

   task automatic t_strided_ext();
      rf[7] = 64'hAAAA_0000_0000_FFF0;
      run_op(2'b00, 2'b10, 0, 0, 1, 1, 0, 2'd1, 8'd3, 7'd5, 7'd7, 7'd20, -1);
      chk("R7 sext count", 64'(n_req), 64'd3);
      for (int i = 0; i < 3; i++)
         chk("R7 strided sign-extended addr", cap_addr[i], rf[5] - 64'(16 * i));
      run_op(2'b00, 2'b10, 0, 0, 1, 0, 0, 2'd1, 8'd3, 7'd5, 7'd7, 7'd20, -1);
      for (int i = 0; i < 3; i++)
         chk("R7 strided zero-extended addr", cap_addr[i], rf[5] + 64'(32'h0000_FFF0 * i));
   endtask

   task automatic t_wrap();
      rf[20] = 64'hFFFF_FFFF_FFFF_FFF8;
      rf[21] = 64'd8;
      run_op(2'b00, 2'b11, 0, 0, 1, 0, 0, 2'd3, 8'd3, 7'd20, 7'd21, 7'd0, -1);
      chk("R6 wrap addr0", cap_addr[0], 64'hFFFF_FFFF_FFFF_FFF8);
      chk("R6 wrap addr1", cap_addr[1], 64'h0);
      chk("R6 wrap addr2", cap_addr[2], 64'h8);
   endtask

   task automatic t_indexed();
      for (int i = 0; i < 3; i++)
         rf[40 + i] = 64'h1234_5600 + 64'(8'h80 + i);
      run_op(2'b00, 2'b00, 1, 1, 1, 1, 0, 2'd0, 8'd3, 7'd30, 7'd40, 7'd50, -1);
      chk("R7 indexed count", 64'(n_req), 64'd3);
      for (int i = 0; i < 3; i++) begin
         chk("R7 indexed zero-extended addr", cap_addr[i], rf[30 + i] + 64'(8'h80 + i));
         chk("R5 indexed ra advances", 64'(cap_ra[i]), 64'(30 + i));
         chk("R5 indexed rb advances", 64'(cap_rb[i]), 64'(40 + i));
      end
      run_op(2'b00, 2'b00, 1, 0, 1, 0, 0, 2'd3, 8'd2, 7'd30, 7'd40, 7'd50, -1);
      chk("R5 scalar offset held", 64'(cap_rb[1]), 64'd40);
      chk("R5 vector base advances", 64'(cap_ra[1]), 64'd31);
   endtask

   task automatic t_scalar_dst();
      run_op(2'b00, 2'b01, 0, 0, 0, 0, 0, 2'd2, 8'd5, 7'd5, 7'd6, 7'd10, -1);
      chk("R3 scalar dst count", 64'(n_req), 64'd1);
      chk("R3 scalar dst done_vl", 64'(got_vl), 64'd5);
   endtask

   task automatic t_scalar_pair();
      run_op(2'b00, 2'b00, 0, 0, 1, 0, 0, 2'd3, 8'd4, 7'd8, 7'd9, 7'd60, -1);
      chk("R4 scalar pair count", 64'(n_req), 64'd1);
      run_op(2'b00, 2'b00, 0, 0, 1, 0, 1, 2'd3, 8'd4, 7'd8, 7'd9, 7'd60, -1);
      chk("R4 inhibited count", 64'(n_req), 64'd4);
      for (int i = 0; i < 4; i++) begin
         chk("R4 inhibited same addr", cap_addr[i], rf[8] + rf[9]);
         chk("R4 inhibited dst", 64'(cap_dst[i]), 64'(60 + i));
      end
   endtask

   task automatic t_ffirst();
      run_op(2'b01, 2'b01, 0, 0, 1, 0, 0, 2'd0, 8'd5, 7'd5, 7'd6, 7'd10, 2);
      chk("R9 late fault count", 64'(n_req), 64'd3);
      chk("R9 late fault done_vl", 64'(got_vl), 64'd2);
      chk("R9 late fault exc", 64'(got_exc), 64'd0);
      run_op(2'b01, 2'b01, 0, 0, 1, 0, 0, 2'd0, 8'd5, 7'd5, 7'd6, 7'd10, 1);
      chk("R11 element1 fault done_vl", 64'(got_vl), 64'd1);
      chk("R11 element1 fault exc", 64'(got_exc), 64'd0);
      run_op(2'b01, 2'b01, 0, 0, 1, 0, 0, 2'd0, 8'd5, 7'd5, 7'd6, 7'd10, 0);
      chk("R8 first fault count", 64'(n_req), 64'd1);
      chk("R8 first fault exc", 64'(got_exc), 64'd1);
      chk("R8 first fault done_vl", 64'(got_vl), 64'd5);
   endtask

   task automatic t_normal_fault();
      for (int m = 0; m < 4; m++) begin
         if (m != 1) begin
            run_op(2'(m), 2'b01, 0, 0, 1, 0, 0, 2'd0, 8'd4, 7'd5, 7'd6, 7'd10, 1);
            chk("R13 fault count", 64'(n_req), 64'd2);
            chk("R13 fault exc", 64'(got_exc), 64'd1);
            chk("R2 mode keeps vl", 64'(got_vl), 64'd4);
         end
      end
   endtask

   task automatic t_redirect();
      rf[61] = 64'h20;
      run_op(2'b01, 2'b00, 1, 1, 1, 0, 0, 2'd3, 8'd3, 7'd60, 7'd61, 7'd70, -1);
      chk("R10 redirect count", 64'(n_req), 64'd3);
      for (int i = 0; i < 3; i++) begin
         chk("R10 redirect addr", cap_addr[i], rf[60] + 64'(32 * i));
         chk("R10 redirect ra fixed", 64'(cap_ra[i]), 64'd60);
         chk("R10 redirect rb fixed", 64'(cap_rb[i]), 64'd61);
      end
   endtask

   initial begin
      for (int i = 0; i < 128; i++)
         rf[i] = 64'h0001_0000_0000_0000 + 64'(i * 32'h1000) + 64'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_vl();
      t_unit();
      t_strided_ext();
      t_wrap();
      t_indexed();
      t_scalar_dst();
      t_scalar_pair();
      t_ffirst();
      t_normal_fault();
      t_redirect();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog R12 actual=expired expected=finished");
      summary();
      $finish;
   end

endmodule